// File: doc/BRIEF.md
# Host command engine for an embedded controller

The block is the device side of a byte-wide host mailbox. It has two ports: a command port and a data port. A host write to the command port chooses an operation. Host writes to the data port supply the address byte and, for a store, the value byte. The block is backed by a 256-byte register space held in flops. It keeps a status byte with an input-buffer-full flag (IBF), an output-buffer-full flag (OBF) and a flag that tells whether the last byte went to the command port.

The engine takes in each host byte one cycle after the byte is written. The result of a fetch is placed in the output buffer, and OBF is then set. Once the first fetch or store command has been taken in, the block enters its interrupt mode. From then on it raises a one-cycle system control interrupt (SCI) pulse each time it takes in a byte and each time it fills the output buffer. A fetch leaves one idle cycle between taking in the address and setting OBF. This keeps the two interrupt pulses of a fetch apart.

Top module: `ec_host_engine`

## Requirements
- R1: After reset, status_o, host_rdata_o and sci_o are all 0, and every byte of the register space reads 0.
- R2: A host write sets IBF (status bit 1) at the next clock edge. It also sets bit 3 to 1 for a command-port write or to 0 for a data-port write. The engine clears IBF at the edge after that.
- R3: Command byte 0x81 followed by two data-port bytes (an address, then a value) stores the value at that address.
- R4: Command byte 0x80 followed by one data-port address byte returns the addressed byte on host_rdata_o. OBF (status bit 0) is set at the third clock edge after the edge that latched the address byte.
- R5: A host read of the data port clears OBF at the next edge. A host read of the command port leaves OBF set.
- R6: No SCI pulse occurs before a 0x80 or 0x81 command byte has been taken in. Taking in that command byte is itself the first SCI event.
- R7: In interrupt mode, sci_o is high for exactly one cycle for each IBF clear and for each OBF set. The pulse is high in the same cycle that the flag change first shows on status_o.
- R8: A data-port byte that arrives while no command is waiting for data is taken in (IBF clears) but changes neither the register space nor the output buffer.
- R9: A command byte other than 0x80 or 0x81 returns the engine to idle and drops any partly received sequence. A new 0x80 or 0x81 command restarts the sequence at once.
- R10: Status bits 2, 4, 5, 6 and 7 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host write strobe, one cycle |
| host_rd_i | input | 1 | Host read strobe, one cycle |
| host_cmd_i | input | 1 | Port select: 1 = command port, 0 = data port |
| host_wdata_i | input | 8 | Byte written by the host |
| host_rdata_o | output | 8 | Output buffer, read through the data port |
| status_o | output | 8 | Status byte: OBF bit 0, IBF bit 1, command/data bit 3 |
| sci_o | output | 1 | System control interrupt pulse |

## Verification
The assertions assume that the host writes only while IBF is clear. They also assume that the host never sends the next byte before the engine has taken in the previous one. The stimulus keeps to this because every write waits until IBF has been seen low at a falling edge. The one-cycle pulse check and the OBF/SCI check also rely on the host not writing during the idle and fill cycles of a fetch. The stimulus meets this because it waits for OBF before it sends anything new.

// File: rtl/ec_host_pkg.sv
package ec_host_pkg;
  localparam logic [7:0] CMD_FETCH = 8'h80;
  localparam logic [7:0] CMD_STORE = 8'h81;

  localparam int unsigned ST_OBF   = 0;
  localparam int unsigned ST_IBF   = 1;
  localparam int unsigned ST_CD    = 3;
  localparam int unsigned ST_BURST = 4;
  localparam int unsigned ST_EVT   = 5;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_RD_ADDR,
    SEQ_WR_ADDR,
    SEQ_WR_DATA,
    SEQ_RD_GAP,
    SEQ_RD_FILL
  } seq_state_e;
endpackage

// File: rtl/ec_reg_space.sv
module ec_reg_space #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[i] <= '0;
      else if (we_i && addr_i == ADDR_W'(i)) mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];

  // R3
  wr_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(addr_i)] == $past(wdata_i));
endmodule

// File: rtl/ec_cmd_seq.sv
module ec_cmd_seq
  import ec_host_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ibf_i,
  input  logic              cd_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic              consume_o,
  output logic              sci_arm_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              load_obuf_o
);
  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              busy;

  // no intake while a fetch is completing
  assign busy      = (state_q == SEQ_RD_GAP) || (state_q == SEQ_RD_FILL);
  assign consume_o = ibf_i && !busy;

  always_comb begin
    state_d     = state_q;
    addr_d      = addr_q;
    sci_arm_o   = 1'b0;
    mem_we_o    = 1'b0;
    load_obuf_o = 1'b0;
    if (consume_o && cd_i) begin
      unique case (byte_i)
        CMD_FETCH: begin state_d = SEQ_RD_ADDR; sci_arm_o = 1'b1; end
        CMD_STORE: begin state_d = SEQ_WR_ADDR; sci_arm_o = 1'b1; end
        default:   state_d = SEQ_IDLE;
      endcase
    end else if (consume_o) begin
      unique case (state_q)
        SEQ_RD_ADDR: begin addr_d = byte_i[ADDR_W-1:0]; state_d = SEQ_RD_GAP; end
        SEQ_WR_ADDR: begin addr_d = byte_i[ADDR_W-1:0]; state_d = SEQ_WR_DATA; end
        SEQ_WR_DATA: begin mem_we_o = 1'b1; state_d = SEQ_IDLE; end
        default:     state_d = state_q;
      endcase
    end else begin
      unique case (state_q)
        SEQ_RD_GAP:  state_d = SEQ_RD_FILL;
        SEQ_RD_FILL: begin load_obuf_o = 1'b1; state_d = SEQ_IDLE; end
        default:     state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = byte_i;

  // R3
  store_on_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ibf_i && !cd_i);

  // R4
  fill_after_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_obuf_o |-> $past(state_q) == SEQ_RD_GAP);
endmodule

// File: rtl/ec_host_buf.sv
module ec_host_buf
  import ec_host_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic              host_cmd_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic              consume_i,
  input  logic              sci_arm_i,
  input  logic              load_obuf_i,
  input  logic [DATA_W-1:0] obuf_data_i,
  output logic              ibf_o,
  output logic              cd_o,
  output logic [DATA_W-1:0] ibuf_o,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic [7:0]        status_o,
  output logic              sci_o
);
  logic              ibf_q, obf_q, cd_q, sci_en_q, sci_q;
  logic [DATA_W-1:0] ibuf_q, obuf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ibf_q  <= 1'b0;
      cd_q   <= 1'b0;
      ibuf_q <= '0;
    end else if (host_wr_i) begin
      ibf_q  <= 1'b1;
      cd_q   <= host_cmd_i;
      ibuf_q <= host_wdata_i;
    end else if (consume_i) begin
      ibf_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      obf_q  <= 1'b0;
      obuf_q <= '0;
    end else if (load_obuf_i) begin
      obf_q  <= 1'b1;
      obuf_q <= obuf_data_i;
    end else if (host_rd_i && !host_cmd_i) begin
      obf_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sci_en_q <= 1'b0;
      sci_q    <= 1'b0;
    end else begin
      if (sci_arm_i) sci_en_q <= 1'b1;
      sci_q <= (consume_i && (sci_en_q || sci_arm_i)) || (load_obuf_i && sci_en_q);
    end
  end

  always_comb begin
    status_o           = '0;
    status_o[ST_OBF]   = obf_q;
    status_o[ST_IBF]   = ibf_q;
    status_o[ST_CD]    = cd_q;
    status_o[ST_BURST] = 1'b0;
    status_o[ST_EVT]   = 1'b0;
  end

  assign ibf_o        = ibf_q;
  assign cd_o         = cd_q;
  assign ibuf_o       = ibuf_q;
  assign host_rdata_o = obuf_q;
  assign sci_o        = sci_q;

  // R7
  sci_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sci_q |=> !sci_q);

  // R7
  obf_sci_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(obf_q) |-> sci_q);

  // R7
  ibf_sci_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ibf_q) && sci_en_q |-> sci_q);

  // R2
  ibf_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ibf_q) |-> $past(host_wr_i));

  // R2
  no_overrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_i |-> !ibf_q);
endmodule

// File: rtl/ec_host_engine.sv
module ec_host_engine #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic              host_cmd_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic [7:0]        status_o,
  output logic              sci_o
);
  logic              ibf, cd, consume, sci_arm, mem_we, load_obuf;
  logic [DATA_W-1:0] ibuf, mem_wdata, mem_rdata;
  logic [ADDR_W-1:0] mem_addr;

  ec_host_buf #(.DATA_W(DATA_W)) u_buf (
    .clk_i, .rst_ni, .host_wr_i, .host_rd_i, .host_cmd_i, .host_wdata_i,
    .consume_i(consume), .sci_arm_i(sci_arm), .load_obuf_i(load_obuf),
    .obuf_data_i(mem_rdata), .ibf_o(ibf), .cd_o(cd), .ibuf_o(ibuf),
    .host_rdata_o, .status_o, .sci_o
  );

  ec_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i, .rst_ni, .ibf_i(ibf), .cd_i(cd), .byte_i(ibuf),
    .consume_o(consume), .sci_arm_o(sci_arm), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .load_obuf_o(load_obuf)
  );

  ec_reg_space #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i, .rst_ni, .we_i(mem_we), .addr_i(mem_addr),
    .wdata_i(mem_wdata), .rdata_o(mem_rdata)
  );
endmodule

// File: tb/ec_host_engine_test.sv
module ec_host_engine_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0, rd = 1'b0, cmd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, status;
  logic       sci;

  int checks = 0, fails = 0;
  int sci_seen = 0, sci_exp = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ec_host_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .host_wr_i(wr), .host_rd_i(rd),
    .host_cmd_i(cmd), .host_wdata_i(wdata), .host_rdata_o(rdata),
    .status_o(status), .sci_o(sci)
  );

  always @(negedge clk) if (rst_n && sci) sci_seen++;

  function automatic logic [7:0] pat(logic [7:0] a);
    return a * 8'd37 + 8'd11;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // returns at the falling edge after the byte was taken in
  task automatic host_write(bit is_cmd, logic [7:0] b, bit exp_sci);
    @(negedge clk);
    wr = 1'b1; cmd = is_cmd; wdata = b;
    @(negedge clk);
    wr = 1'b0;
    chk(status[1] == 1'b1, "R2 ibf set", status[1], 1);
    chk(status[3] == is_cmd, "R2 cd flag", status[3], is_cmd);
    @(negedge clk);
    chk(status[1] == 1'b0, "R2 ibf clear", status[1], 0);
    chk(sci == exp_sci, "R7 sci on ibf clear", sci, exp_sci);
    chk((status & 8'hF4) == 0, "R10 reserved bits", status, status & 8'h0B);
    if (exp_sci) sci_exp++;
  endtask

  task automatic fetch(logic [7:0] a, logic [7:0] exp);
    host_write(1'b1, 8'h80, 1'b1);
    host_write(1'b0, a, 1'b1);
    @(negedge clk);
    chk(status[0] == 1'b0 && sci == 1'b0, "R4 gap cycle", {status[0], sci}, 0);
    @(negedge clk);
    chk(status[0] == 1'b1, "R4 obf set", status[0], 1);
    chk(sci == 1'b1, "R7 sci on obf set", sci, 1);
    chk(rdata == exp, "R4 fetch data", rdata, exp);
    sci_exp++;
    rd = 1'b1; cmd = 1'b1;
    @(negedge clk);
    chk(sci == 1'b0, "R7 single pulse", sci, 0);
    chk(status[0] == 1'b1, "R5 cmd-port read keeps obf", status[0], 1);
    cmd = 1'b0;
    @(negedge clk);
    rd = 1'b0;
    chk(status[0] == 1'b0, "R5 data read clears obf", status[0], 0);
    chk(sci == 1'b0, "R7 no sci on obf clear", sci, 0);
  endtask

  task automatic store(logic [7:0] a, logic [7:0] v);
    host_write(1'b1, 8'h81, 1'b1);
    host_write(1'b0, a, 1'b1);
    host_write(1'b0, v, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(status == 8'h00, "R1 reset status", status, 0);
    chk(rdata == 8'h00, "R1 reset rdata", rdata, 0);
    chk(sci == 1'b0, "R1 reset sci", sci, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // before interrupt mode: ignored data byte, unknown command
    host_write(1'b0, 8'h33, 1'b0);   // R8 R6
    host_write(1'b1, 8'h55, 1'b0);   // R9 R6
    chk(sci_seen == 0, "R6 no sci before mode", sci_seen, 0);
    chk(status[0] == 1'b0, "R8 no output from idle data", status[0], 0);

    fetch(8'h10, 8'h00);             // R1 cleared space, R6 arms
    fetch(8'hFF, 8'h00);             // R1

    for (int a = 0; a < 256; a++) store(8'(a), pat(8'(a)));    // R3
    for (int a = 0; a < 256; a++) fetch(8'(a), pat(8'(a)));    // R3 R4

    // R8: data byte in idle after mode entry
    host_write(1'b0, 8'hEE, 1'b1);
    chk(status[0] == 1'b0, "R8 no obf", status[0], 0);
    fetch(8'hEE, pat(8'hEE));
    fetch(8'h00, pat(8'h00));

    // R9: abandon a store, then stray data byte
    host_write(1'b1, 8'h81, 1'b1);
    host_write(1'b0, 8'h20, 1'b1);
    host_write(1'b1, 8'h42, 1'b1);
    host_write(1'b0, 8'h99, 1'b1);
    fetch(8'h20, pat(8'h20));
    fetch(8'h99, pat(8'h99));

    // R9: restart fetch with store
    host_write(1'b1, 8'h80, 1'b1);
    store(8'h30, 8'h5A);
    fetch(8'h30, 8'h5A);
    fetch(8'h31, pat(8'h31));

    repeat (3) @(negedge clk);
    chk(sci_seen == sci_exp, "R7 sci pulse count", sci_seen, sci_exp);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule